// File: doc/BRIEF.md
# Universal Bidirectional Bus Register

This block moves data words between an A side and a B side, one independent path per direction. Each path holds a single storage word that can act in three ways. While its latch enable is high the word follows the input. While the latch enable is low it either keeps its value or, on a rising edge of that path's own external clock, captures the input. An active-low clock enable can block that capture. An active-low output enable decides whether the far side sees the word.

All state is clocked by one internal sampling clock `clk_i`. The two external clock inputs are treated as asynchronous. Each one passes through a synchronizer of `SYNC_STAGES` flops and then an edge detector. A rising external clock edge therefore reaches the storage `SYNC_STAGES + 1` sampling cycles after it happens. Latch enable, clock enable, output enable and data are taken as synchronous to `clk_i`. Each bus is modelled as an input vector, an output vector and a valid flag. A disabled side drives all zeros and a low valid flag, which stands in for high impedance.

Top module: `ubr_top`

## Requirements
- R1: While a path's latch enable is high, its stored word takes the input word sampled at each `clk_i` edge, whatever the external clock and clock enable do.
- R2: With latch enable low and active-low clock enable low, a rising edge on the path's external clock captures the input word. The word is visible within `SYNC_STAGES + 1` sampling cycles.
- R3: With latch enable low and the external clock static, or falling, the stored word does not change while the input changes.
- R4: With latch enable low and active-low clock enable high, external clock edges have no effect on the stored word.
- R5: When latch enable falls while the external clock is high, the word held is the last input seen while latch enable was high. It stays until a later qualified rising edge captures the current input.
- R6: The active-low output enable is registered. One cycle after it is low, the side's valid flag is 1 and the side's output shows the stored word. While valid is 0, the output is all zeros.
- R7: The B-to-A path (input `b_i`, output `a_o`) behaves like the A-to-B path (input `a_i`, output `b_o`). Control activity on one path never changes the other path's word or valid flag.
- R8: While `rst_ni` is low, both stored words are zero and both valid flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | WIDTH | A-side input word, source of the A-to-B path |
| a_o | output | WIDTH | A-side output word, driven by the B-to-A path |
| a_vld_o | output | 1 | A-side output valid (0 = high impedance) |
| b_i | input | WIDTH | B-side input word, source of the B-to-A path |
| b_o | output | WIDTH | B-side output word, driven by the A-to-B path |
| b_vld_o | output | 1 | B-side output valid (0 = high impedance) |
| ab_oe_ni | input | 1 | A-to-B output enable, active low |
| ab_le_i | input | 1 | A-to-B latch enable |
| ab_clk_i | input | 1 | A-to-B external capture clock (asynchronous) |
| ab_cken_ni | input | 1 | A-to-B clock enable, active low |
| ba_oe_ni | input | 1 | B-to-A output enable, active low |
| ba_le_i | input | 1 | B-to-A latch enable |
| ba_clk_i | input | 1 | B-to-A external capture clock (asynchronous) |
| ba_cken_ni | input | 1 | B-to-A clock enable, active low |

## Verification
The case that is hardest to reach is R5. The latch enable has to drop while the external clock already stands high, and the input has to change in the same cycle. The held word must then survive until a separate low-then-high clock cycle. To get there, the stimulus raises the clock first while the path is transparent, loads a known word, and then lowers the latch enable together with the data change. It then lets the synchronizer drain before it lowers and raises the clock again. Random operation sequences also leave a path with its clock high or low before the next operation. This puts stale-level and pending-edge situations in front of the hold and block checks.

// File: rtl/ubr_pkg.sv
package ubr_pkg;

  typedef enum logic [1:0] {
    ST_HOLD    = 2'd0,
    ST_THRU    = 2'd1,
    ST_CAPTURE = 2'd2
  } st_op_e;

  // latch enable dominates; edge capture needs enable low (active low)
  function automatic st_op_e pick_op(input logic le, input logic cken_n, input logic rise);
    if (le)                  return ST_THRU;
    else if (!cken_n && rise) return ST_CAPTURE;
    else                      return ST_HOLD;
  endfunction

endpackage

// File: rtl/ubr_clk_edge.sv
module ubr_clk_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_clk_i,
  output logic rise_o
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[0] <= 1'b0;
          else         sync_q[0] <= ext_clk_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[i] <= 1'b0;
          else         sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[LAST];
  end

  assign rise_o = sync_q[LAST] & ~prev_q;

  // R2: a detected rising edge is a single-cycle pulse
  assert_single_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);

endmodule

// File: rtl/ubr_dir_path.sv
module ubr_dir_path
  import ubr_pkg::*;
#(
  parameter int WIDTH       = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] din_i,
  input  logic             le_i,
  input  logic             ext_clk_i,
  input  logic             cken_ni,
  input  logic             oe_ni,
  output logic [WIDTH-1:0] dout_o,
  output logic             vld_o
);

  logic             rise;
  st_op_e           op;
  logic [WIDTH-1:0] store_q;
  logic             en_q;

  ubr_clk_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ext_clk_i(ext_clk_i),
    .rise_o   (rise)
  );

  assign op = pick_op(le_i, cken_ni, rise);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      store_q <= '0;
    end else begin
      unique case (op)
        ST_THRU, ST_CAPTURE: store_q <= din_i;
        default:             store_q <= store_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= ~oe_ni;
  end

  assign vld_o  = en_q;
  assign dout_o = en_q ? store_q : '0;

  assert_thru_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    le_i |=> store_q == $past(din_i));

  assert_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && !cken_ni && rise) |=> store_q == $past(din_i));

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && !rise) |=> $stable(store_q));

  assert_blocked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && cken_ni) |=> $stable(store_q));

  assert_enable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> vld_o == !$past(oe_ni));

endmodule

// File: rtl/ubr_top.sv
module ubr_top #(
  parameter int WIDTH       = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] a_i,
  output logic [WIDTH-1:0] a_o,
  output logic             a_vld_o,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] b_o,
  output logic             b_vld_o,
  input  logic             ab_oe_ni,
  input  logic             ab_le_i,
  input  logic             ab_clk_i,
  input  logic             ab_cken_ni,
  input  logic             ba_oe_ni,
  input  logic             ba_le_i,
  input  logic             ba_clk_i,
  input  logic             ba_cken_ni
);

  localparam int NDIR = 2;  // 0: A to B, 1: B to A

  logic [WIDTH-1:0] din  [NDIR];
  logic [WIDTH-1:0] dout [NDIR];
  logic [NDIR-1:0]  le, eclk, cken_n, oe_n, vld;

  assign din[0] = a_i;
  assign din[1] = b_i;
  assign le     = {ba_le_i,    ab_le_i};
  assign eclk   = {ba_clk_i,   ab_clk_i};
  assign cken_n = {ba_cken_ni, ab_cken_ni};
  assign oe_n   = {ba_oe_ni,   ab_oe_ni};

  generate
    for (genvar d = 0; d < NDIR; d++) begin : g_dir
      ubr_dir_path #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_path (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .din_i    (din[d]),
        .le_i     (le[d]),
        .ext_clk_i(eclk[d]),
        .cken_ni  (cken_n[d]),
        .oe_ni    (oe_n[d]),
        .dout_o   (dout[d]),
        .vld_o    (vld[d])
      );
    end
  endgenerate

  assign b_o     = dout[0];
  assign b_vld_o = vld[0];
  assign a_o     = dout[1];
  assign a_vld_o = vld[1];

  assert_b_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !b_vld_o |-> b_o == '0);
  assert_a_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !a_vld_o |-> a_o == '0);

  // R8: reset value seen on the ports
  always_comb begin
    if (!rst_ni) begin
      assert_reset_R8: assert (!a_vld_o && !b_vld_o && a_o == '0 && b_o == '0);
    end
  end

endmodule

// File: tb/ubr_top_test.sv
module ubr_top_test;

  localparam int W       = 18;
  localparam int S       = 2;
  localparam int PERIOD  = 10;
  localparam int SETTLE  = S + 3;
  localparam int WD_CYC  = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  logic [W-1:0] din  [2];
  logic         le   [2];
  logic         eclk [2];
  logic         ckn  [2];
  logic         oen  [2];
  logic [W-1:0] expw [2];

  logic [W-1:0] a_o, b_o;
  logic         a_vld, b_vld;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  ubr_top #(.WIDTH(W), .SYNC_STAGES(S)) uut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .a_i       (din[0]),
    .a_o       (a_o),
    .a_vld_o   (a_vld),
    .b_i       (din[1]),
    .b_o       (b_o),
    .b_vld_o   (b_vld),
    .ab_oe_ni  (oen[0]),
    .ab_le_i   (le[0]),
    .ab_clk_i  (eclk[0]),
    .ab_cken_ni(ckn[0]),
    .ba_oe_ni  (oen[1]),
    .ba_le_i   (le[1]),
    .ba_clk_i  (eclk[1]),
    .ba_cken_ni(ckn[1])
  );

  function automatic logic [W-1:0] exp_out(input logic [W-1:0] w, input logic oe_n);
    return oe_n ? '0 : w;
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_dir(input int d, input string req);
    logic [W-1:0] act_d, exp_d;
    logic         act_v;
    act_d = (d == 0) ? b_o : a_o;
    act_v = (d == 0) ? b_vld : a_vld;
    exp_d = exp_out(expw[d], oen[d]);
    checks++;
    if (act_d !== exp_d || act_v !== !oen[d]) begin
      errors++;
      $display("FAIL %s dir%0d data %h exp %h valid %b exp %b",
               req, d, act_d, exp_d, act_v, !oen[d]);
    end
  endtask

  task automatic check_both(input int d, input string req);
    check_dir(d, req);
    check_dir(1 - d, "R7");
  endtask

  task automatic op_thru(input int d);
    le[d]  = 1'b1;
    din[d] = W'($urandom);
    for (int i = 0; i < SETTLE; i++) begin
      eclk[d] = 1'($urandom);
      ckn[d]  = 1'($urandom);
      step(1);
    end
    expw[d] = din[d];
    check_both(d, "R1");
  endtask

  task automatic op_cap(input int d);
    le[d] = 1'b0; ckn[d] = 1'b0; eclk[d] = 1'b0;
    step(SETTLE);
    din[d] = W'($urandom);
    step(1);
    eclk[d] = 1'b1;
    step(SETTLE);
    expw[d] = din[d];
    check_both(d, "R2");
  endtask

  task automatic op_block(input int d);
    le[d] = 1'b0; ckn[d] = 1'b1; eclk[d] = 1'b0;
    step(SETTLE);
    din[d] = W'($urandom);
    step(1);
    eclk[d] = 1'b1;
    step(SETTLE);
    eclk[d] = 1'b0;
    step(SETTLE);
    check_both(d, "R4");
  endtask

  task automatic op_hold(input int d);
    le[d] = 1'b0;
    ckn[d] = 1'($urandom);
    step(SETTLE);
    for (int i = 0; i < SETTLE; i++) begin
      din[d] = W'($urandom);
      eclk[d] = 1'b0;  // static low or falling only
      step(1);
    end
    check_both(d, "R3");
  endtask

  task automatic op_lefall(input int d);
    logic [W-1:0] held;
    le[d] = 1'b1;
    held = W'($urandom);
    din[d] = held;
    step(1);
    eclk[d] = 1'b1;
    ckn[d] = 1'b0;
    step(SETTLE);
    le[d] = 1'b0;
    din[d] = ~held;
    step(SETTLE);
    expw[d] = held;
    check_both(d, "R5");
    eclk[d] = 1'b0;
    step(SETTLE);
    check_both(d, "R5");
    eclk[d] = 1'b1;
    step(SETTLE);
    expw[d] = ~held;
    check_both(d, "R5");
  endtask

  task automatic run_op(input int d, input int k);
    case (k)
      0: op_thru(d);
      1: op_cap(d);
      2: op_block(d);
      3: op_hold(d);
      default: op_lefall(d);
    endcase
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int d = 0; d < 2; d++) begin
      din[d] = '1; le[d] = 1'b0; eclk[d] = 1'b0; ckn[d] = 1'b0; oen[d] = 1'b0;
      expw[d] = '0;
    end
    step(3);
    oen[0] = 1'b1; oen[1] = 1'b1;
    check_dir(0, "R8");
    check_dir(1, "R8");
    oen[0] = 1'b0; oen[1] = 1'b0;
    step(1);
    checks++;
    if (a_vld !== 1'b0 || b_vld !== 1'b0 || a_o !== '0 || b_o !== '0) begin
      errors++;
      $display("FAIL R8 in reset a %h/%b b %h/%b exp 0/0", a_o, a_vld, b_o, b_vld);
    end
    rst_n = 1'b1;
    step(2);
    check_dir(0, "R8");
    check_dir(1, "R8");

    // directed pass over every operation, both paths
    for (int d = 0; d < 2; d++)
      for (int k = 0; k < 5; k++) run_op(d, k);

    // R6: disable then re-enable one side
    oen[0] = 1'b1; step(1);
    check_both(0, "R6");
    oen[0] = 1'b0; step(1);
    check_both(0, "R6");

    for (int i = 0; i < 80; i++) begin
      int d;
      d = int'($urandom_range(0, 1));
      oen[d] = 1'($urandom_range(0, 3) == 0);
      run_op(d, int'($urandom_range(0, 4)));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired exp finish before %0d cycles", WD_CYC);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule